// File: doc/BRIEF.md
# Crosstalk Link Test Pattern Generator

This block drives test vectors onto an N-wire point-to-point link to expose crosstalk defects under the maximum-aggressor model. One wire at a time is the victim. All other wires are aggressors and always carry the same value as each other. For each victim the block walks a fixed eight-step sequence. Each step-to-step transition sets up one of the six crosstalk errors on the victim: rising or falling delay, positive or negative glitch, and rising or falling speedup. After the eighth step, the one-hot victim position rotates by one wire toward the MSB and the walk repeats. The run ends once every wire has been the victim.

A six-bit enable mask selects which error classes matter. Vectors that no enabled transition needs are still stepped through, but they are not marked valid. A receive-side comparator sits on the far end of the link. It holds each emitted vector for one cycle and compares it with what arrives. On a miscompare it reports the victim index and step number of the failing vector.

Top module: `xtalk_walk_top`

## Requirements
- R1: In reset and while idle, tx_pat_o is all zeros and tx_valid_o, done_o and mism_o are low.
- R2: A start_i pulse seen while idle begins a run, and the first vector appears in the next cycle with wire 0 as victim. err_en_i is captured at that moment. start_i and err_en_i have no effect while a run is in progress.
- R3: At step k (0..7) the victim wire carries 1,0,1,1,0,1,0,0 and every aggressor carries 1,0,1,0,1,0,0,1, in that order of k. Steps advance one per cycle.
- R4: After step 7 of victim v, the next cycle shows step 0 with victim v+1, so the victim bit moves up by one position.
- R5: err_en_i bits are bit0 rising delay (step 4 to 5), bit1 falling delay (3 to 4), bit2 positive glitch (6 to 7), bit3 negative glitch (2 to 3), bit4 rising speedup (1 to 2) and bit5 falling speedup (0 to 1). tx_valid_o is high on a step exactly when an enabled transition starts or ends on it.
- R6: A run lasts exactly 8*N_WIRES cycles whatever the mask, and done_o is seen 8*N_WIRES+1 cycles after the cycle start_i was applied.
- R7: done_o is high for exactly one cycle, in the cycle after step 7 of the last wire, and the block is idle from then on.
- R8: mism_o is high in a cycle when the vector emitted in the previous cycle was valid and rx_pat_i differs from it. mism_victim_o and mism_step_o then give that vector's victim index and step.
- R9: A vector not marked valid never raises mism_o, whatever arrives on rx_pat_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a run (used only when idle) |
| err_en_i | input | 6 | Error-class enable mask |
| tx_pat_o | output | N_WIRES | Vector driven onto the link |
| tx_valid_o | output | 1 | Current vector is part of the enabled test |
| done_o | output | 1 | One-cycle end-of-run pulse |
| rx_pat_i | input | N_WIRES | Vector received from the link, one cycle late |
| mism_o | output | 1 | Received vector differs from the expected one |
| mism_victim_o | output | VIDX_W | Victim index of the failing vector |
| mism_step_o | output | 3 | Step number of the failing vector |

## Verification
The assertions assume that the link adds exactly one cycle of latency, so that rx_pat_i in a cycle belongs to the vector emitted in the previous cycle. They also assume N_WIRES is at least two, so that the one-hot victim can rotate. The bench loops tx_pat_o back through a one-cycle register to respect the latency assumption. It breaks that loopback only by flipping a single bit at chosen cycles. It raises start_i both while idle and in the middle of runs, and changes the mask between runs, so that the capture-at-start behaviour is exercised under legal input.

// File: rtl/xtalk_pkg.sv
package xtalk_pkg;
  localparam int STEPS  = 8;
  localparam int STEP_W = 3;
  localparam int ERR_W  = 6;

  // error-class bit positions in the enable mask
  localparam int E_RDLY = 0;
  localparam int E_FDLY = 1;
  localparam int E_PGL  = 2;
  localparam int E_NGL  = 3;
  localparam int E_RSPD = 4;
  localparam int E_FSPD = 5;

  typedef logic [STEP_W-1:0] step_t;
  typedef logic [ERR_W-1:0]  errmask_t;

  // level on the victim wire at a given step
  function automatic logic victim_level(step_t s);
    case (s)
      3'd0, 3'd2, 3'd3, 3'd5: return 1'b1;
      default:                return 1'b0;
    endcase
  endfunction

  // common level on all aggressor wires at a given step
  function automatic logic aggr_level(step_t s);
    case (s)
      3'd0, 3'd2, 3'd4, 3'd7: return 1'b1;
      default:                return 1'b0;
    endcase
  endfunction

  // is the transition leaving step s one the mask asks for
  function automatic logic trans_enabled(step_t s, errmask_t m);
    case (s)
      3'd0:    return m[E_FSPD];
      3'd1:    return m[E_RSPD];
      3'd2:    return m[E_NGL];
      3'd3:    return m[E_FDLY];
      3'd4:    return m[E_RDLY];
      3'd6:    return m[E_PGL];
      default: return 1'b0;
    endcase
  endfunction

  // a step is needed when an enabled transition launches from or lands on it
  function automatic logic step_needed(step_t s, errmask_t m);
    logic from_prev;
    from_prev = (s != '0) ? trans_enabled(s - step_t'(1), m) : 1'b0;
    return trans_enabled(s, m) | from_prev;
  endfunction
endpackage

// File: rtl/xtalk_walk_seq.sv
module xtalk_walk_seq
  import xtalk_pkg::*;
#(
  parameter int N_WIRES = 8,
  parameter int VIDX_W  = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  errmask_t           err_en_i,
  output logic               busy_o,
  output step_t              step_o,
  output logic [VIDX_W-1:0]  vidx_o,
  output logic [N_WIRES-1:0] vic_oh_o,
  output errmask_t           mask_o,
  output logic               done_o
);
  localparam logic [VIDX_W-1:0]  LAST_V = VIDX_W'(N_WIRES - 1);
  localparam logic [N_WIRES-1:0] OH_0   = N_WIRES'(1);

  logic               busy_q;
  step_t              step_q;
  logic [VIDX_W-1:0]  vidx_q;
  logic [N_WIRES-1:0] oh_q;
  errmask_t           mask_q;
  logic               done_q;

  // named internal events
  logic accept_w, step_wrap_w, last_vic_w, run_end_w;
  assign accept_w    = start_i && !busy_q;
  assign step_wrap_w = busy_q && (step_q == step_t'(STEPS - 1));
  assign last_vic_w  = (vidx_q == LAST_V);
  assign run_end_w   = step_wrap_w && last_vic_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      step_q <= '0;
      vidx_q <= '0;
      oh_q   <= OH_0;
      mask_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= run_end_w;
      if (accept_w) begin
        busy_q <= 1'b1;
        step_q <= '0;
        vidx_q <= '0;
        oh_q   <= OH_0;
        mask_q <= err_en_i;
      end else if (busy_q) begin
        step_q <= step_q + step_t'(1);
        if (step_wrap_w) begin
          if (last_vic_w) begin
            busy_q <= 1'b0;
          end else begin
            vidx_q <= vidx_q + VIDX_W'(1);
            oh_q   <= {oh_q[N_WIRES-2:0], oh_q[N_WIRES-1]};
          end
        end
      end
    end
  end

  assign busy_o   = busy_q;
  assign step_o   = step_q;
  assign vidx_o   = vidx_q;
  assign vic_oh_o = oh_q;
  assign mask_o   = mask_q;
  assign done_o   = done_q;
endmodule

// File: rtl/xtalk_vec_drive.sv
module xtalk_vec_drive
  import xtalk_pkg::*;
#(
  parameter int N_WIRES = 8
) (
  input  logic               busy_i,
  input  step_t              step_i,
  input  logic [N_WIRES-1:0] vic_oh_i,
  input  errmask_t           mask_i,
  output logic [N_WIRES-1:0] pat_o,
  output logic               valid_o
);
  logic vlev_w, alev_w;
  assign vlev_w = victim_level(step_i);
  assign alev_w = aggr_level(step_i);

  for (genvar i = 0; i < N_WIRES; i++) begin : g_wire
    assign pat_o[i] = busy_i && (vic_oh_i[i] ? vlev_w : alev_w);
  end

  assign valid_o = busy_i && step_needed(step_i, mask_i);
endmodule

// File: rtl/xtalk_rx_cmp.sv
module xtalk_rx_cmp
  import xtalk_pkg::*;
#(
  parameter int N_WIRES = 8,
  parameter int VIDX_W  = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_WIRES-1:0] exp_pat_i,
  input  logic               exp_valid_i,
  input  logic [VIDX_W-1:0]  exp_vidx_i,
  input  step_t              exp_step_i,
  input  logic [N_WIRES-1:0] rx_pat_i,
  output logic               mism_o,
  output logic [VIDX_W-1:0]  mism_vidx_o,
  output step_t              mism_step_o
);
  logic [N_WIRES-1:0] pat_q;
  logic               val_q;
  logic [VIDX_W-1:0]  vidx_q;
  step_t              step_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pat_q  <= '0;
      val_q  <= 1'b0;
      vidx_q <= '0;
      step_q <= '0;
    end else begin
      pat_q  <= exp_pat_i;
      val_q  <= exp_valid_i;
      vidx_q <= exp_vidx_i;
      step_q <= exp_step_i;
    end
  end

  assign mism_o      = val_q && (rx_pat_i != pat_q);
  assign mism_vidx_o = mism_o ? vidx_q : '0;
  assign mism_step_o = mism_o ? step_q : '0;
endmodule

// File: rtl/xtalk_walk_top.sv
module xtalk_walk_top
  import xtalk_pkg::*;
#(
  parameter  int N_WIRES = 8,
  localparam int VIDX_W  = (N_WIRES > 1) ? $clog2(N_WIRES) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [5:0]         err_en_i,
  output logic [N_WIRES-1:0] tx_pat_o,
  output logic               tx_valid_o,
  output logic               done_o,
  input  logic [N_WIRES-1:0] rx_pat_i,
  output logic               mism_o,
  output logic [VIDX_W-1:0]  mism_victim_o,
  output logic [2:0]         mism_step_o
);
  logic               busy_w;
  step_t              step_w;
  logic [VIDX_W-1:0]  vidx_w;
  logic [N_WIRES-1:0] vic_oh_w;
  errmask_t           mask_w;

  xtalk_walk_seq #(.N_WIRES(N_WIRES), .VIDX_W(VIDX_W)) seq_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .err_en_i (err_en_i),
    .busy_o   (busy_w),
    .step_o   (step_w),
    .vidx_o   (vidx_w),
    .vic_oh_o (vic_oh_w),
    .mask_o   (mask_w),
    .done_o   (done_o)
  );

  xtalk_vec_drive #(.N_WIRES(N_WIRES)) drv_i (
    .busy_i   (busy_w),
    .step_i   (step_w),
    .vic_oh_i (vic_oh_w),
    .mask_i   (mask_w),
    .pat_o    (tx_pat_o),
    .valid_o  (tx_valid_o)
  );

  xtalk_rx_cmp #(.N_WIRES(N_WIRES), .VIDX_W(VIDX_W)) cmp_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .exp_pat_i   (tx_pat_o),
    .exp_valid_i (tx_valid_o),
    .exp_vidx_i  (vidx_w),
    .exp_step_i  (step_w),
    .rx_pat_i    (rx_pat_i),
    .mism_o      (mism_o),
    .mism_vidx_o (mism_victim_o),
    .mism_step_o (mism_step_o)
  );
endmodule

// File: rtl/xtalk_walk_sva.sv
module xtalk_walk_sva #(
  parameter int N_WIRES = 8,
  parameter int VIDX_W  = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               start_i,
  input logic               busy,
  input logic [2:0]         step,
  input logic [VIDX_W-1:0]  vidx,
  input logic [N_WIRES-1:0] vic_oh,
  input logic [5:0]         mask,
  input logic               tx_valid,
  input logic               done,
  input logic               mism
);
  localparam logic [VIDX_W-1:0] LAST_V = VIDX_W'(N_WIRES - 1);

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> !tx_valid);

  p_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy) |=> (busy && step == 3'd0 && vidx == '0));

  p_mask_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !(step == 3'd7 && vidx == LAST_V)) |=> (busy && $stable(mask)));

  p_step_inc_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && step != 3'd7) |=> (busy && step == $past(step) + 3'd1 && $stable(vidx)));

  p_victim_next_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && step == 3'd7 && vidx != LAST_V) |=> (busy && step == 3'd0 && vidx == $past(vidx) + VIDX_W'(1)));

  p_oh_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> ($countones(vic_oh) == 1 && vic_oh[vidx]));

  p_done_after_last_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && step == 3'd7 && vidx == LAST_V) |=> (done && !busy));

  p_done_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> !done);

  p_mism_needs_valid_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mism |-> $past(tx_valid));
endmodule

bind xtalk_walk_top xtalk_walk_sva #(.N_WIRES(N_WIRES), .VIDX_W(VIDX_W)) sva_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .busy     (busy_w),
  .step     (step_w),
  .vidx     (vidx_w),
  .vic_oh   (vic_oh_w),
  .mask     (mask_w),
  .tx_valid (tx_valid_o),
  .done     (done_o),
  .mism     (mism_o)
);

// File: tb/xtalk_walk_tb.sv
module xtalk_walk_top_tb_top;
  localparam int W  = 8;
  localparam int VW = $clog2(W);
  // step tables, bit k = step k
  localparam logic [7:0] VTAB = 8'b0010_1101;
  localparam logic [7:0] ATAB = 8'b1001_0101;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [5:0]    err_en = '0;
  logic [W-1:0]  tx_pat, rx_pat;
  logic          tx_valid, done, mism;
  logic [VW-1:0] mism_v;
  logic [2:0]    mism_s;

  always #4 clk = ~clk;

  xtalk_walk_top #(.N_WIRES(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .err_en_i(err_en),
    .tx_pat_o(tx_pat), .tx_valid_o(tx_valid), .done_o(done),
    .rx_pat_i(rx_pat), .mism_o(mism), .mism_victim_o(mism_v), .mism_step_o(mism_s)
  );

  int n_run = 0, n_fail = 0, cyc = 0;
  int inj_at = -1, start_at = -100, done_at = -1, n_valid = 0, n_done = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s cycle %0d: actual=%0h expected=%0h", tag, cyc, act, exp);
    end
  endtask

  // mask bit excited by the transition leaving step k, -1 for none
  function automatic int class_of(int k);
    case (k)
      0: return 5;  1: return 4;  2: return 3;
      3: return 1;  4: return 0;  6: return 2;
      default: return -1;
    endcase
  endfunction

  function automatic bit needed(int k, logic [5:0] m);
    bit r = 0;
    if (class_of(k) >= 0 && m[class_of(k)]) r = 1;
    if (k > 0 && class_of(k-1) >= 0 && m[class_of(k-1)]) r = 1;
    return r;
  endfunction

  // behavioural reference model
  bit         m_busy = 0, m_done = 0;
  int         m_v = 0, m_k = 0;
  logic [5:0] m_mask = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_v = 0; m_k = 0;
    end else begin
      m_done = m_busy && m_k == 7 && m_v == W-1;
      if (m_busy) begin
        if (m_k == 7) begin
          m_k = 0;
          if (m_v == W-1) m_busy = 0; else m_v++;
        end else m_k++;
      end else if (start) begin
        m_busy = 1; m_v = 0; m_k = 0; m_mask = err_en;
      end
    end
  end

  logic [W-1:0] last_tx = '0, p_pat = '0;
  bit           p_val = 0;
  int           p_v = 0, p_k = 0;

  always @(negedge clk) begin
    logic [W-1:0] e_pat;
    bit e_val, e_mism;
    string tg;
    cyc++;
    rx_pat = last_tx ^ ((cyc == inj_at) ? (W'(1) << (cyc % W)) : '0);
    #1;
    e_pat = '0;
    if (m_busy) for (int i = 0; i < W; i++) e_pat[i] = (i == m_v) ? VTAB[m_k] : ATAB[m_k];
    e_val = m_busy && needed(m_k, m_mask);
    tg = m_busy ? "R3 pattern" : "R1 idle pattern";
    chk(tx_pat === e_pat, tg, tx_pat, e_pat);
    chk(tx_valid === e_val, m_busy ? "R5 valid" : "R1 idle valid", tx_valid, e_val);
    chk(done === m_done, "R7 done", done, m_done);
    e_mism = p_val && (rx_pat != p_pat);
    chk(mism === e_mism, p_val ? "R8 mismatch" : "R9 mismatch", mism, e_mism);
    if (e_mism) begin
      chk(mism_v == VW'(p_v), "R8 victim index", mism_v, p_v);
      chk(int'(mism_s) == p_k, "R8 step", mism_s, p_k);
    end
    if (start && !m_busy && rst_n) start_at = cyc;
    if (cyc == start_at + 1)
      chk(tx_pat === '1, "R2 first vector", tx_pat, {W{1'b1}});
    if (cyc == start_at + 12)   // victim 1, step 3
      chk(tx_pat === W'(2), "R4 second victim", tx_pat, 2);
    if (tx_valid) n_valid++;
    if (done) begin
      n_done++;
      chk(cyc - start_at == 8*W + 1, "R6 run length", cyc - start_at, 8*W + 1);
    end
    p_val = e_val; p_pat = e_pat; p_v = m_v; p_k = m_k;
    last_tx = tx_pat;
    if (cyc > 20000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic run_walk(input logic [5:0] m, input int inj_off, input int poke_off);
    int expv = 0;
    for (int k = 0; k < 8; k++) if (needed(k, m)) expv++;
    @(negedge clk);
    n_valid = 0; n_done = 0;
    inj_at = cyc + 1 + inj_off;
    start = 1'b1; err_en = m;
    @(negedge clk);
    start = 1'b0; err_en = ~m;
    for (int c = 0; c < 8*W + 4; c++) begin
      @(negedge clk);
      if (c == poke_off) begin start = 1'b1; err_en = 6'h3F; end
      else start = 1'b0;
    end
    start = 1'b0;
    @(negedge clk);
    chk(n_valid == expv * W, "R5 valid count", n_valid, expv * W);
    chk(n_done == 1, "R7 done count", n_done, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(tx_pat === '0 && !tx_valid && !done && !mism, "R1 reset state", tx_pat, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run_walk(6'h3F, 10, 20);      // full mask, miscompare, start ignored mid-run
    run_walk(6'b001010, 3, 5);    // glitch+delay subset, inject on a valid step
    run_walk(6'b001010, 7, -1);   // inject on a skipped step
    run_walk(6'b000000, 9, 30);   // nothing valid: no miscompare possible
    run_walk(6'b100100, 13, -1);  // falling speedup and positive glitch
    chk(tx_pat === '0 && !tx_valid && !done, "R1 idle after runs", tx_pat, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule